// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block is a clocked controller that converts single-beat read and write requests into timed access cycles on an external asynchronous static RAM. Requests arrive on a ready/valid bus and responses leave on it. The RAM has these controls:

- an active-low select and an active-high select, which must both be asserted;
- an active-low read (output) enable;
- an active-low write strobe;
- two active-low byte-lane enables;
- an organization pin that chooses 16-bit words or 8-bit bytes.

Every timing window is a count of system clock cycles. Each count is derived at elaboration from the clock period and from the RAM's nanosecond minimums. The controller drives the RAM's data lines through a separate output value and output-enable, which go to a tri-state pad outside this block.

A request is accepted only while the controller is idle, and the request's organization bit is latched at that point. The cycle has four steps:

1. The address and selects are applied for a setup count with the strobes high.
2. Either the write strobe is pulsed or the read enable is held low for the access count.
3. A write holds its data for a hold count. A read registers the RAM data and waits out a bus turnaround count.
4. A single-cycle response pulse reports completion.

Top module: `sram_ctl`

## Requirements
- R1: After reset and while idle, the controller holds these values: active-low select = 1, active-high select = 0, read enable = 1, write strobe = 1, pad enable = 0, req_ready = 1 and rsp_valid = 0. The organization pin reads 1 (word mode).
- R2: A request is accepted only on a clock edge where req_valid and req_ready are both high. req_ready drops on the next cycle and stays low until the cycle finishes. Each accepted request produces exactly one rsp_valid pulse, which is one cycle long.
- R3: While a cycle is in progress, the active-low select is 0 and the active-high select is 1 at the same time. When the cycle finishes, both are returned to their inactive levels together.
- R4: The write strobe is high whenever the address, the address LSB or the organization pin changes. The strobe stays low for WR_CYC = max(ceil(35 ns/T), ceil(30 ns/T)) cycles, which is 9 at T = 4 ns.
- R5: The pad enable rises together with the write strobe's falling edge. It stays high for HOLD_CYC = max(1, ceil(70 ns/T) − SETUP_CYC − WR_CYC) cycles after the strobe rises, which is 8. It is low again when the write response is given, and at that time req_ready is already high. The write response comes 1 + WR_CYC + HOLD_CYC = 18 cycles after acceptance.
- R6: A read holds the read enable low while the write strobe is high. The read data is registered on the edge that ends ACC_CYC = max(ceil(70 ns/T) − SETUP_CYC, ceil(35 ns/T)) = 17 cycles. The read response comes 1 + ACC_CYC = 18 cycles after acceptance, with SETUP_CYC = 1.
- R7: In word mode, the address pins carry req_addr[ADDR_W−1:0] and the address LSB pin is 0. Lane enable bit 0 (data lines 7:0) is ~req_be[0], and bit 1 (lines 15:8) is ~req_be[1]. A read returns zero on any lane that is not enabled. A write changes only the enabled lanes, and a write with req_be = 00 changes nothing.
- R8: In byte mode (req_byte_mode = 1), the organization pin is 0 and the address pins carry req_addr[ADDR_W:1]. The address LSB pin carries req_addr[0] and the lane enables are 2'b10. The write data is req_wdata[7:0] on lines 7:0. Read data is lines 7:0, zero-extended to 16 bits.
- R9: After a read, the pad enable is not raised until TURN_CYC = ceil(30 ns/T) = 8 cycles have passed since the read enable rose. req_ready returns exactly TURN_CYC cycles after the read response.
- R10: The organization bit is sampled only at acceptance. Changing req_byte_mode while a cycle is in progress leaves that cycle's pins and its response unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W+1 | Word index (word mode) or byte index (byte mode) |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane enables for word mode |
| req_byte_mode | input | 1 | 1 = byte organization for this request |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, masked or zero-extended |
| sram_addr | output | ADDR_W | RAM address pins |
| sram_addr_lsb | output | 1 | Extra LSB address pin used in byte mode |
| sram_wide | output | 1 | Organization pin, 1 = 16-bit words |
| sram_sel_n | output | 1 | Active-low select |
| sram_sel | output | 1 | Active-high select |
| sram_rd_n | output | 1 | Active-low read (output) enable |
| sram_wr_n | output | 1 | Active-low write strobe |
| sram_lane_n | output | 2 | Active-low lane enables, bit 0 = lines 7:0 |
| sram_dq_out | output | 16 | Value driven onto the data pad |
| sram_dq_oe | output | 1 | Data pad drive enable |
| sram_dq_in | input | 16 | Value read from the data pad |

## Verification
The bench RAM model gives valid data only after 70 ns of address stability and 35 ns of read enable. Otherwise it returns a fixed junk word, and it puts junk on unselected lanes. A capture that is too early, or a missing lane mask, therefore shows up as a wrong data value.

The stimulus covers the following patterns:
- full-word writes and single-lane writes, which separate lane gating from whole-word writes;
- a write with no lanes enabled, which shows that the RAM is left deselected;
- byte-mode writes and reads, read back in word mode, which separate LSB pin placement from lane placement;
- back-to-back requests that alternate organization, which show that the organization bit is latched at acceptance and not followed live.

The model times every strobe, checks data setup, and checks the pad turnaround after each read.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_WHOLD,
    ST_TURN
  } seq_state_t;

  // whole clock cycles needed to cover a nanosecond minimum
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int at_least(input int v, input int floor_v);
    return (v < floor_v) ? floor_v : v;
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
`timescale 1ns/1ps
module sram_ctl_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/sram_ctl_lanes.sv
`timescale 1ns/1ps
module sram_ctl_lanes #(
  parameter int LANE_W = 8,
  parameter int LANES  = 2,
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic              byte_mode,
  input  logic [LANES-1:0]  be,
  input  logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  lane_n,
  output logic [DATA_W-1:0] wbus,
  output logic [DATA_W-1:0] rmask
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_low
      // lane 0 carries the byte in byte organization
      assign lane_n[g] = byte_mode ? 1'b0 : ~be[g];
      assign wbus[g*LANE_W +: LANE_W]  = wdata[g*LANE_W +: LANE_W];
      assign rmask[g*LANE_W +: LANE_W] = {LANE_W{byte_mode | be[g]}};
    end else begin : g_high
      assign lane_n[g] = byte_mode ? 1'b1 : ~be[g];
      assign wbus[g*LANE_W +: LANE_W]  = byte_mode ? '0 : wdata[g*LANE_W +: LANE_W];
      assign rmask[g*LANE_W +: LANE_W] = {LANE_W{~byte_mode & be[g]}};
    end
  end

endmodule

// File: rtl/sram_ctl_seq.sv
`timescale 1ns/1ps
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 16,
  parameter int LANES     = 2,
  parameter int CNT_W     = 5,
  parameter int SETUP_CYC = 1,
  parameter int WR_CYC    = 9,
  parameter int HOLD_CYC  = 8,
  parameter int ACC_CYC   = 17,
  parameter int TURN_CYC  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W:0]   req_addr,
  input  logic              req_byte_mode,
  input  logic [LANES-1:0]  lane_n_in,
  input  logic [DATA_W-1:0] wbus_in,
  input  logic [DATA_W-1:0] rmask_in,
  input  logic              tmr_expired,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_addr_lsb,
  output logic              sram_wide,
  output logic              sram_sel_n,
  output logic              sram_sel,
  output logic              sram_rd_n,
  output logic              sram_wr_n,
  output logic [LANES-1:0]  sram_lane_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);

  localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_WR    = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] LD_ACC   = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] LD_TURN  = CNT_W'(TURN_CYC - 1);

  seq_state_t        state;
  logic              write_q;
  logic [DATA_W-1:0] mask_q;

  assign req_ready = (state == ST_IDLE);

  // window length for the state about to be entered
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state)
      ST_IDLE: begin
        if (req_valid) begin
          tmr_load = 1'b1;
          tmr_val  = LD_SETUP;
        end
      end
      ST_SETUP: begin
        if (tmr_expired) begin
          tmr_load = 1'b1;
          tmr_val  = write_q ? LD_WR : LD_ACC;
        end
      end
      ST_STROBE: begin
        if (tmr_expired) begin
          tmr_load = 1'b1;
          tmr_val  = write_q ? LD_HOLD : LD_TURN;
        end
      end
      default: begin
        tmr_load = 1'b0;
        tmr_val  = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      write_q       <= 1'b0;
      mask_q        <= '0;
      rsp_valid     <= 1'b0;
      rsp_rdata     <= '0;
      sram_addr     <= '0;
      sram_addr_lsb <= 1'b0;
      sram_wide     <= 1'b1;
      sram_sel_n    <= 1'b1;
      sram_sel      <= 1'b0;
      sram_rd_n     <= 1'b1;
      sram_wr_n     <= 1'b1;
      sram_lane_n   <= '1;
      sram_dq_out   <= '0;
      sram_dq_oe    <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            write_q <= req_write;
            mask_q  <= rmask_in;
            if (req_byte_mode) begin
              sram_addr     <= req_addr[ADDR_W:1];
              sram_addr_lsb <= req_addr[0];
            end else begin
              sram_addr     <= req_addr[ADDR_W-1:0];
              sram_addr_lsb <= 1'b0;
            end
            sram_wide   <= ~req_byte_mode;
            sram_lane_n <= lane_n_in;
            sram_dq_out <= wbus_in;
            sram_sel_n  <= 1'b0;
            sram_sel    <= 1'b1;
            state       <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (tmr_expired) begin
            if (write_q) begin
              sram_wr_n  <= 1'b0;
              sram_dq_oe <= 1'b1;
            end else begin
              sram_rd_n <= 1'b0;
            end
            state <= ST_STROBE;
          end
        end
        ST_STROBE: begin
          if (tmr_expired) begin
            if (write_q) begin
              sram_wr_n <= 1'b1;
              state     <= ST_WHOLD;
            end else begin
              sram_rd_n  <= 1'b1;
              sram_sel_n <= 1'b1;
              sram_sel   <= 1'b0;
              rsp_rdata  <= sram_dq_in & mask_q;
              rsp_valid  <= 1'b1;
              state      <= ST_TURN;
            end
          end
        end
        ST_WHOLD: begin
          if (tmr_expired) begin
            sram_dq_oe <= 1'b0;
            sram_sel_n <= 1'b1;
            sram_sel   <= 1'b0;
            rsp_valid  <= 1'b1;
            state      <= ST_IDLE;
          end
        end
        ST_TURN: begin
          if (tmr_expired) begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int LANE_W   = 8,
  parameter int CLK_NS   = 4,
  parameter int T_AS_NS  = 0,
  parameter int T_WP_NS  = 35,
  parameter int T_DW_NS  = 30,
  parameter int T_WC_NS  = 70,
  parameter int T_AA_NS  = 70,
  parameter int T_OE_NS  = 35,
  parameter int T_OHZ_NS = 30,
  localparam int LANES   = 2,
  localparam int DATA_W  = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W:0]   req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  input  logic              req_byte_mode,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_addr_lsb,
  output logic              sram_wide,
  output logic              sram_sel_n,
  output logic              sram_sel,
  output logic              sram_rd_n,
  output logic              sram_wr_n,
  output logic [LANES-1:0]  sram_lane_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);

  localparam int SETUP_CYC = at_least(ns_to_cyc(T_AS_NS, CLK_NS), 1);
  localparam int WR_CYC    = at_least(at_least(ns_to_cyc(T_WP_NS, CLK_NS),
                                               ns_to_cyc(T_DW_NS, CLK_NS)), 1);
  localparam int HOLD_CYC  = at_least(ns_to_cyc(T_WC_NS, CLK_NS) - SETUP_CYC - WR_CYC, 1);
  localparam int ACC_CYC   = at_least(at_least(ns_to_cyc(T_AA_NS, CLK_NS) - SETUP_CYC,
                                               ns_to_cyc(T_OE_NS, CLK_NS)), 1);
  localparam int TURN_CYC  = at_least(ns_to_cyc(T_OHZ_NS, CLK_NS), 1);
  localparam int MAX_CYC   = at_least(at_least(at_least(SETUP_CYC, WR_CYC),
                                               at_least(HOLD_CYC, ACC_CYC)), TURN_CYC);
  localparam int CNT_W     = at_least($clog2(MAX_CYC + 1), 1);

  logic [LANES-1:0]  lane_n;
  logic [DATA_W-1:0] wbus;
  logic [DATA_W-1:0] rmask;
  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              tmr_expired;

  sram_ctl_lanes #(
    .LANE_W (LANE_W),
    .LANES  (LANES)
  ) u_lanes (
    .byte_mode (req_byte_mode),
    .be        (req_be),
    .wdata     (req_wdata),
    .lane_n    (lane_n),
    .wbus      (wbus),
    .rmask     (rmask)
  );

  sram_ctl_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sram_ctl_seq #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .LANES     (LANES),
    .CNT_W     (CNT_W),
    .SETUP_CYC (SETUP_CYC),
    .WR_CYC    (WR_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .ACC_CYC   (ACC_CYC),
    .TURN_CYC  (TURN_CYC)
  ) u_seq (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .req_byte_mode (req_byte_mode),
    .lane_n_in     (lane_n),
    .wbus_in       (wbus),
    .rmask_in      (rmask),
    .tmr_expired   (tmr_expired),
    .tmr_load      (tmr_load),
    .tmr_val       (tmr_val),
    .rsp_valid     (rsp_valid),
    .rsp_rdata     (rsp_rdata),
    .sram_addr     (sram_addr),
    .sram_addr_lsb (sram_addr_lsb),
    .sram_wide     (sram_wide),
    .sram_sel_n    (sram_sel_n),
    .sram_sel      (sram_sel),
    .sram_rd_n     (sram_rd_n),
    .sram_wr_n     (sram_wr_n),
    .sram_lane_n   (sram_lane_n),
    .sram_dq_out   (sram_dq_out),
    .sram_dq_oe    (sram_dq_oe),
    .sram_dq_in    (sram_dq_in)
  );

endmodule

// File: rtl/sram_ctl_chk.sv
`timescale 1ns/1ps
module sram_ctl_chk #(
  parameter int ADDR_W   = 17,
  parameter int TURN_CYC = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_addr_lsb,
  input logic              sram_wide,
  input logic              sram_sel_n,
  input logic              sram_sel,
  input logic              sram_rd_n,
  input logic              sram_wr_n,
  input logic              sram_dq_oe
);

  int gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap <= TURN_CYC;
    end else if (!sram_rd_n) begin
      gap <= 0;
    end else if (gap < TURN_CYC) begin
      gap <= gap + 1;
    end
  end

  assert_sel_pair_R3: assert property (@(posedge clk) disable iff (rst)
    (sram_sel_n == 1'b0) == (sram_sel == 1'b1));

  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!sram_wr_n && $past(!sram_wr_n)) |-> ($stable(sram_addr) && $stable(sram_addr_lsb)));

  assert_pad_in_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    sram_dq_oe |-> !sram_sel_n);

  assert_pad_with_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_dq_oe) |-> !sram_wr_n);

  assert_read_not_write_R6: assert property (@(posedge clk) disable iff (rst)
    !sram_rd_n |-> sram_wr_n);

  assert_rsp_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  assert_turnaround_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_dq_oe) |-> (gap >= TURN_CYC));

  assert_org_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && $past(!req_ready)) |-> $stable(sram_wide));

endmodule

bind sram_ctl sram_ctl_chk #(
  .ADDR_W   (ADDR_W),
  .TURN_CYC (TURN_CYC)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .sram_addr     (sram_addr),
  .sram_addr_lsb (sram_addr_lsb),
  .sram_wide     (sram_wide),
  .sram_sel_n    (sram_sel_n),
  .sram_sel      (sram_sel),
  .sram_rd_n     (sram_rd_n),
  .sram_wr_n     (sram_wr_n),
  .sram_dq_oe    (sram_dq_oe)
);

// File: tb/sram_ctl_test.sv
`timescale 1ns/1ps
module sram_ctl_test;

  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;
  // expected counts at a 4 ns clock, from the requirement formulas
  localparam int E_WR   = 9;   // max(ceil(35/4), ceil(30/4))
  localparam int E_HOLD = 8;   // max(1, ceil(70/4) - 1 - 9)
  localparam int E_ACC  = 17;  // max(ceil(70/4) - 1, ceil(35/4))
  localparam int E_TURN = 8;   // ceil(30/4)

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW:0]   req_addr = '0;
  logic [15:0]   req_wdata = '0;
  logic [1:0]    req_be = 2'b11;
  logic          req_byte_mode = 1'b0;
  logic          rsp_valid;
  logic [15:0]   rsp_rdata;
  logic [AW-1:0] sram_addr;
  logic          sram_addr_lsb, sram_wide, sram_sel_n, sram_sel;
  logic          sram_rd_n, sram_wr_n, sram_dq_oe;
  logic [1:0]    sram_lane_n;
  logic [15:0]   sram_dq_out;
  logic [15:0]   sram_dq_in = 16'hDEAD;

  sram_ctl #(.ADDR_W(AW), .CLK_NS(4)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .req_byte_mode(req_byte_mode), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .sram_addr(sram_addr), .sram_addr_lsb(sram_addr_lsb),
    .sram_wide(sram_wide), .sram_sel_n(sram_sel_n), .sram_sel(sram_sel),
    .sram_rd_n(sram_rd_n), .sram_wr_n(sram_wr_n), .sram_lane_n(sram_lane_n),
    .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- RAM model ----------------
  logic [7:0] mem [2*DEPTH];
  realtime t_addr = 0, t_rd = 0, t_wr = 0, t_dq = 0, t_rel = -1000;
  logic ram_sel, ram_drive;
  assign ram_sel   = !sram_sel_n && sram_sel && (!sram_wide || (sram_lane_n != 2'b11));
  assign ram_drive = ram_sel && !sram_rd_n && sram_wr_n;

  initial for (int i = 0; i < 2*DEPTH; i++) mem[i] = 8'h00;

  always @(sram_addr, sram_addr_lsb, sram_wide) begin
    t_addr = $realtime;
    if (!rst && !sram_wr_n) chk(1'b0, "R4 address moved under strobe", 32'(sram_addr), 0);
  end
  always @(negedge sram_rd_n) t_rd = $realtime;
  always @(negedge sram_wr_n) t_wr = $realtime;
  always @(sram_dq_out, posedge sram_dq_oe) t_dq = $realtime;
  always @(negedge ram_drive) t_rel = $realtime;

  always @(posedge sram_dq_oe) begin
    chk(!ram_drive && ($realtime - t_rel >= 30.0), "R9 pad driven inside turnaround",
        32'($rtoi($realtime - t_rel)), 30);
  end

  always @(posedge sram_wr_n) begin
    if (!rst && ram_sel) begin
      chk($realtime - t_wr >= 35.0, "R4 strobe width ns", 32'($rtoi($realtime - t_wr)), 35);
      chk(sram_dq_oe && ($realtime - t_dq >= 30.0), "R5 data setup ns",
          32'($rtoi($realtime - t_dq)), 30);
      if (!sram_wide) begin
        mem[{sram_addr, sram_addr_lsb}] = sram_dq_out[7:0];
      end else begin
        if (!sram_lane_n[0]) mem[{sram_addr, 1'b0}] = sram_dq_out[7:0];
        if (!sram_lane_n[1]) mem[{sram_addr, 1'b1}] = sram_dq_out[15:8];
      end
    end
  end

  initial begin
    #0.5;
    forever begin
      #1;
      if (ram_drive && ($realtime - t_addr >= 70.0) && ($realtime - t_rd >= 35.0)) begin
        if (!sram_wide)
          sram_dq_in = {8'h5A, mem[{sram_addr, sram_addr_lsb}]};
        else
          sram_dq_in = {sram_lane_n[1] ? 8'hA5 : mem[{sram_addr, 1'b1}],
                        sram_lane_n[0] ? 8'hA5 : mem[{sram_addr, 1'b0}]};
      end else begin
        sram_dq_in = 16'hDEAD;
      end
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    bit          rd;
    logic [15:0] exp;
    int          acc;
    string       tag;
  } sb_item_t;
  sb_item_t sbq[$];
  logic [7:0] shadow [2*DEPTH];
  initial for (int i = 0; i < 2*DEPTH; i++) shadow[i] = 8'h00;

  task automatic issue(input bit wr, input int a, input logic [1:0] be,
                       input logic [15:0] d, input bit bm, input string tag);
    sb_item_t it;
    it.rd  = !wr;
    it.tag = tag;
    it.exp = '0;
    if (wr) begin
      if (bm) shadow[a] = d[7:0];
      else begin
        if (be[0]) shadow[2*a]   = d[7:0];
        if (be[1]) shadow[2*a+1] = d[15:8];
      end
    end else begin
      if (bm) it.exp = {8'h00, shadow[a]};
      else    it.exp = {be[1] ? shadow[2*a+1] : 8'h00, be[0] ? shadow[2*a] : 8'h00};
    end
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = (AW+1)'(a);
    req_be = be; req_wdata = d; req_byte_mode = bm;
    while (!req_ready) @(negedge clk);
    it.acc = cyc + 1;
    sbq.push_back(it);
    @(negedge clk);
    req_valid = 1'b0;
    req_byte_mode = ~bm;  // flipped while busy: must not matter (R10)
    chk(!req_ready, "R2 ready low after accept", 32'(req_ready), 0);
    chk(!sram_sel_n && sram_sel, "R3 selects asserted", {30'd0, sram_sel_n, sram_sel}, 1);
    if (bm) begin
      chk(!sram_wide && sram_addr == a[AW:1] && sram_addr_lsb == a[0] && sram_lane_n == 2'b10,
          "R8 byte pins", {sram_wide, sram_addr_lsb, sram_lane_n, 20'd0, sram_addr},
          {1'b0, a[0], 2'b10, 20'd0, a[AW:1]});
    end else begin
      chk(sram_wide && sram_addr == a[AW-1:0] && !sram_addr_lsb && sram_lane_n == ~be,
          "R7 word pins", {sram_wide, sram_addr_lsb, sram_lane_n, 20'd0, sram_addr},
          {1'b1, 1'b0, ~be, 20'd0, a[AW-1:0]});
    end
  endtask

  bit prev_rsp = 1'b0;
  bit turn_pend = 1'b0;
  int turn_from = 0;
  always @(negedge clk) begin
    if (turn_pend && req_ready) begin
      chk(cyc - turn_from == E_TURN, "R9 ready after read", 32'(cyc - turn_from), E_TURN);
      turn_pend = 1'b0;
    end
    if (!rst && sram_wide !== 1'bx && rsp_valid) begin
      sb_item_t it;
      chk(!prev_rsp, "R2 response pulse length", 32'(prev_rsp), 0);
      if (sbq.size() == 0) begin
        chk(1'b0, "R2 response without request", 1, 0);
      end else begin
        it = sbq.pop_front();
        chk(sram_sel_n && !sram_sel, "R3 deselected at end", {30'd0, sram_sel_n, sram_sel}, 2);
        if (it.rd) begin
          chk(cyc - it.acc == 1 + E_ACC, "R6 read latency", 32'(cyc - it.acc), 1 + E_ACC);
          chk(rsp_rdata == it.exp, it.tag, 32'(rsp_rdata), 32'(it.exp));
          turn_pend = 1'b1;
          turn_from = cyc;
        end else begin
          chk(cyc - it.acc == 1 + E_WR + E_HOLD, "R5 write latency", 32'(cyc - it.acc),
              1 + E_WR + E_HOLD);
          chk(!sram_dq_oe && req_ready, "R5 pad released, ready",
              {30'd0, sram_dq_oe, req_ready}, 1);
        end
      end
    end
    prev_rsp = rsp_valid;
  end

  // ---------------- sequence ----------------
  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sram_sel_n && !sram_sel, "R1 selects idle", {30'd0, sram_sel_n, sram_sel}, 2);
    chk(sram_rd_n && sram_wr_n, "R1 strobes idle", {30'd0, sram_rd_n, sram_wr_n}, 3);
    chk(!sram_dq_oe && sram_wide, "R1 pad off, word org", {30'd0, sram_dq_oe, sram_wide}, 1);
    chk(req_ready && !rsp_valid, "R1 ready, no response", {30'd0, req_ready, rsp_valid}, 2);

    issue(1, 5, 2'b11, 16'h1234, 0, "R7 write full word");
    issue(0, 5, 2'b11, 16'h0000, 0, "R6 read full word");
    issue(1, 5, 2'b01, 16'hABCD, 0, "R7 low lane write");
    issue(0, 5, 2'b11, 16'h0000, 0, "R7 read after low lane write");
    issue(1, 5, 2'b10, 16'h5678, 0, "R7 high lane write");
    issue(0, 5, 2'b01, 16'h0000, 0, "R7 read low lane only");
    issue(0, 5, 2'b10, 16'h0000, 0, "R7 read high lane only");
    issue(1, 5, 2'b00, 16'hFFFF, 0, "R7 no-lane write");
    issue(0, 5, 2'b11, 16'h0000, 0, "R7 no-lane write left word unchanged");

    issue(1, 32'h20, 2'b00, 16'h9977, 1, "R8 byte write even");
    issue(1, 32'h21, 2'b11, 16'h6688, 1, "R8 byte write odd");
    issue(0, 32'h20, 2'b00, 16'h0000, 1, "R8 byte read even zero-extended");
    issue(0, 32'h21, 2'b00, 16'h0000, 1, "R10 byte read, mode flipped while busy");
    issue(0, 32'h10, 2'b11, 16'h0000, 0, "R8 word read of byte pair");

    for (int k = 0; k < 6; k++)
      issue(1, 64 + k, 2'b11, 16'(16'h3C00 + k * 16'h0111), 0, "R6 pattern write");
    for (int k = 0; k < 6; k++) begin
      issue(0, 64 + k, 2'b11, 16'h0000, 0, "R6 pattern read");
      issue(0, 2*(64 + k) + 1, 2'b00, 16'h0000, 1, "R10 alternating byte read");
    end
    issue(1, 255, 2'b11, 16'hFACE, 0, "R7 top word write");
    issue(0, 255, 2'b11, 16'h0000, 0, "R6 top word read");

    while (sbq.size() != 0 || !req_ready) @(negedge clk);
    repeat (20) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule